// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves 8-bit data between two ports, A and B, in either direction. Each port has a capture register with its own clock. The register samples that port's incoming data on the rising edge of the clock. The register runs whether or not the port is being driven.

For each direction, a select input chooses what drives the far port:
- the live data arriving at the near port, or
- the value held in the near port's register.

A low-active output enable and a direction input decide which port, if any, is driven. When the enable is inactive (isolation), both ports go undriven. Both registers can still be loaded during isolation and their contents sent out later.

Each bidirectional pin group is split into three vectors: an input, an output and a per-port output enable. A pad ring or a bench can then resolve the actual bus.

Top module: `regxcvr`

## Requirements
- R1: An active-low asynchronous reset (`rst_n`) clears both registers to 0. After reset, with the stored source selected, a driven port shows 8'h00.
- R2: On each rising edge of `clk_a`, the A register loads `a_in`. Edges of `clk_b` do not change it.
- R3: On each rising edge of `clk_b`, the B register loads `b_in`. Edges of `clk_a` do not change it.
- R4: While `oe_n` is 1, both `a_oe` and `b_oe` are 0, whatever `dir` is.
- R5: While `oe_n` is 0:
  - `dir`=1 gives `b_oe`=1 and `a_oe`=0 (A drives B).
  - `dir`=0 gives `a_oe`=1 and `b_oe`=0 (B drives A).
  - The two enables are never 1 together.
- R6: While `b_oe` is 1, `b_out` is selected by `sel_ab`. With `sel_ab`=0 it equals the current `a_in`, combinationally. With `sel_ab`=1 it equals the A register.
- R7: While `a_oe` is 1, `a_out` is selected by `sel_ba`. With `sel_ba`=0 it equals the current `b_in`, combinationally. With `sel_ba`=1 it equals the B register.
- R8: Captures made while `oe_n` is 1 are kept. They are driven out once `oe_n` goes to 0 with the stored source selected.
- R9: In transceiver mode, the undriven (input) port can be captured into either register or both. Each register keeps its value between its own clock edges, even while its port's input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_a | input | 1 | Capture clock for the A register |
| clk_b | input | 1 | Capture clock for the B register |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: A drives B, 0: B drives A |
| sel_ab | input | 1 | Source for B: 0 live A, 1 A register |
| sel_ba | input | 1 | Source for A: 0 live B, 1 B register |
| a_in | input | 8 | Data arriving at port A |
| a_out | output | 8 | Data driven onto port A |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | 8 | Data arriving at port B |
| b_out | output | 8 | Data driven onto port B |
| b_oe | output | 1 | Drive enable for port B |

## Verification
The hardest state to reach is stored data that was loaded during isolation and is later driven after the live inputs have moved on. Reaching it takes three phases in order: clock edges with `oe_n` high, new input values, then an enabled stored-source read.

The stimulus has directed sequences that build exactly that order. It also has a seeded random loop that mixes isolation-mode clocking with enabled cycles. It ends with a sweep over all sixteen enable, direction and select combinations, each made against fresh known register contents.

// File: rtl/regxcvr.sv
module regxcvr #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) reg_a <= '0;
    else        reg_a <= a_in;

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) reg_b <= '0;
    else        reg_b <= b_in;

  assign b_oe  = !oe_n &&  dir;
  assign a_oe  = !oe_n && !dir;
  assign b_out = sel_ab ? reg_a : a_in;
  assign a_out = sel_ba ? reg_b : b_in;

endmodule

// File: rtl/regxcvr_chk.sv
module regxcvr_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         clk_a,
  input logic         clk_b,
  input logic         oe_n,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b
);

  logic seen_a, seen_b;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) seen_a <= 1'b0;
    else        seen_a <= 1'b1;

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) seen_b <= 1'b0;
    else        seen_b <= 1'b1;

  assert_capture_a_R2: assert property (@(posedge clk_a) disable iff (!rst_n)
    seen_a |-> reg_a == $past(a_in));

  assert_capture_b_R3: assert property (@(posedge clk_b) disable iff (!rst_n)
    seen_b |-> reg_b == $past(b_in));

  assert_isolate_R4: assert property (@(posedge clk_a) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe));

  assert_exclusive_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
    $countones({a_oe, b_oe}) == (oe_n ? 0 : 1));

  assert_b_source_R6: assert property (@(posedge clk_a) disable iff (!rst_n)
    b_oe |-> b_out == (sel_ab ? reg_a : a_in));

  assert_a_source_R7: assert property (@(posedge clk_b) disable iff (!rst_n)
    a_oe |-> a_out == (sel_ba ? reg_b : b_in));

endmodule

bind regxcvr regxcvr_chk #(.W(W)) u_chk (
  .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b), .oe_n(oe_n),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
  .reg_a(reg_a), .reg_b(reg_b)
);

// File: tb/tb_regxcvr.sv
module tb_regxcvr;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, clk_a = 1'b0, clk_b = 1'b0;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [7:0] a_in = '0, b_in = '0, a_out, b_out;
  logic a_oe, b_oe;

  regxcvr dut (
    .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  int checks = 0, fails = 0;
  logic [7:0] m_ra = '0, m_rb = '0;

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic exp_boe(logic n, logic d); return !n && d;  endfunction
  function automatic logic exp_aoe(logic n, logic d); return !n && !d; endfunction

  task automatic pulse(logic ea, logic eb);
    #2;
    if (ea) begin clk_a = 1'b1; m_ra = a_in; end
    if (eb) begin clk_b = 1'b1; m_rb = b_in; end
    #3;
    clk_a = 1'b0; clk_b = 1'b0;
    #2;
  endtask

  task automatic check_all(string tag);
    #1;
    chk({tag, " b_oe R4/R5"}, {7'd0, b_oe}, {7'd0, exp_boe(oe_n, dir)});
    chk({tag, " a_oe R4/R5"}, {7'd0, a_oe}, {7'd0, exp_aoe(oe_n, dir)});
    if (b_oe) chk({tag, " b_out R6"}, b_out, sel_ab ? m_ra : a_in);
    if (a_oe) chk({tag, " a_out R7"}, a_out, sel_ba ? m_rb : b_in);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    #20;
    // R1: reset clears stored values
    sel_ab = 1; sel_ba = 1; oe_n = 0; dir = 1; a_in = 8'hFF; b_in = 8'hEE;
    #1; chk("R1 b_out after reset", b_out, 8'h00);
    dir = 0; #1; chk("R1 a_out after reset", a_out, 8'h00);
    rst_n = 1; #5;

    // R8: capture during isolation, drive later
    oe_n = 1; dir = 1;
    check_all("R4 isolation");
    a_in = 8'h5A; pulse(1, 0);
    b_in = 8'hC3; pulse(0, 1);
    a_in = 8'h11; b_in = 8'h22;
    oe_n = 0; dir = 1; sel_ab = 1; #1; chk("R8 stored A driven", b_out, 8'h5A);
    dir = 0; sel_ba = 1; #1; chk("R8 stored B driven", a_out, 8'hC3);

    // R2/R3: each clock touches only its own register
    a_in = 8'h77; pulse(0, 1);
    dir = 1; #1; chk("R2 A unchanged by clk_b", b_out, 8'h5A);
    b_in = 8'h99; pulse(1, 0);
    dir = 0; #1; chk("R3 B unchanged by clk_a", a_out, 8'h22);
    dir = 1; #1; chk("R2 A loaded by clk_a", b_out, 8'h77);

    // R9: transceiver mode, input port captured into both registers at once
    oe_n = 0; dir = 0; a_in = 8'h3C; b_in = 8'hA5; pulse(1, 1);
    a_in = 8'h00; b_in = 8'h00;
    sel_ba = 1; #1; chk("R9 B register held", a_out, 8'hA5);
    dir = 1; sel_ab = 1; #1; chk("R9 A register held", b_out, 8'h3C);
    sel_ab = 0; a_in = 8'h6B; #1; chk("R6 live A", b_out, 8'h6B);
    dir = 0; sel_ba = 0; b_in = 8'h4D; #1; chk("R7 live B", a_out, 8'h4D);

    // all 16 control combinations
    for (int c = 0; c < 16; c++) begin
      a_in = 8'(c * 17 + 3); b_in = 8'(c * 29 + 7);
      oe_n = 1; pulse(1, 1);
      a_in = ~a_in; b_in = ~b_in;
      {oe_n, dir, sel_ab, sel_ba} = 4'(c);
      check_all("sweep R6/R7");
    end

    // seeded random
    for (int i = 0; i < 400; i++) begin
      a_in = 8'($urandom); b_in = 8'($urandom);
      {oe_n, dir, sel_ab, sel_ba} = 4'($urandom);
      pulse(1'($urandom), 1'($urandom));
      a_in = 8'($urandom); b_in = 8'($urandom);
      check_all("random R2/R3/R6/R7");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule